// File: doc/BRIEF.md
# Pointer Address Generator with Modulo and Bit-Reversed Updates

This block forms data-memory addresses for a signal-processing datapath. It holds a small file of address registers. Each slot has three 16-bit registers: a pointer, a step (offset) and a modifier. Each access names a slot and an addressing mode. In the same cycle the block returns the effective address. It also computes the updated pointer, which is written back on the clock edge when the access is valid.

The modifier of the selected slot decides how every pointer sum is formed:

- **All ones:** plain linear arithmetic modulo 2^16.
- **Zero:** reverse-carry arithmetic, where the carry runs from the most significant bit toward the least significant bit. This walks buffers in bit-reversed order for FFT passes.
- **Any other value m:** a circular buffer of length L = m + 1. The buffer is placed in the aligned power-of-two block that contains the pointer.

Separate load ports initialise the registers before use.

Top module: `agu_top`

## Requirements
- R1: After reset every pointer and step register is 0 and every modifier is 16'hFFFF, which selects linear arithmetic.
- R2: A load writes ld_data on the clock edge into the register chosen by ld_sel (0 pointer, 1 step, 2 modifier, 3 nothing) of slot ld_idx. When a pointer load and an access write-back hit the same slot in one cycle, the load wins.
- R3: Mode codes are 0 (r), 1 (r+n), 2 (r)+, 3 (r)-, 4 -(r), 5 (r)+n, 6 (r)-n and 7 reserved. Modes 0, 1 and 7 never change the pointer. Mode 7 behaves like mode 0.
- R4: The post-modify modes 2, 3, 5 and 6 output ea = r in the access cycle. On the next edge they write r+1, r-1, r+n or r-n, formed with the slot's modifier arithmetic.
- R5: Mode 4 outputs ea = r-1, formed with the modifier arithmetic, and writes that same value back into the pointer.
- R6: With modifier 16'hFFFF, sums and differences wrap modulo 2^16.
- R7: With a modifier m from 1 to 16'hFFFE, let L = m+1 and let B be the smallest power of two that is at least L. The pointer bits above log2(B) are kept. The low part moves by the step and wraps into the range 0..L-1. This holds while the low part starts below L and the step is at most L.
- R8: With modifier 0, a step is added or subtracted with reverse-carry propagation across all 16 bits.
- R9: Only the accessed slot's pointer changes. Nothing changes when acc_valid is low.
- R10: Mode 1 outputs r+n, formed with the slot's modifier arithmetic, and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 0 pointer, 1 step, 2 modifier, 3 none |
| ld_idx | input | 3 | Slot to load |
| ld_data | input | 16 | Load value |
| acc_valid | input | 1 | Access strobe; enables pointer write-back |
| acc_idx | input | 3 | Slot used by the access |
| acc_mode | input | 3 | Addressing mode code |
| ea | output | 16 | Effective address, combinational in the access cycle |

## Verification
The checks on modular behaviour rest on two conditions for a circular-buffer modifier. First, the pointer's offset inside its aligned block must already lie below L. Second, any step must not exceed L. Outside those conditions a single correction cannot bring the result back into range.

The stimulus sets up every modular case with a block-aligned base plus an in-range offset. It uses steps of 1, 2 and L only. Linear and reverse-carry cases have no such limit, so they use extreme pointers and steps. Slot indices always stay within the eight implemented slots.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;

  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_IDX     = 3'd1,
    AM_POSTINC = 3'd2,
    AM_POSTDEC = 3'd3,
    AM_PREDEC  = 3'd4,
    AM_POSTADD = 3'd5,
    AM_POSTSUB = 3'd6,
    AM_RSVD    = 3'd7
  } am_e;

  typedef enum logic [1:0] {
    LD_PTR  = 2'd0,
    LD_STEP = 2'd1,
    LD_MOD  = 2'd2,
    LD_NONE = 2'd3
  } ldsel_e;

  // wr: write back, use_n: step register instead of 1,
  // neg: subtract, pre: address is the updated value
  typedef struct packed {
    logic wr;
    logic use_n;
    logic neg;
    logic pre;
  } am_ctl_t;

  function automatic am_ctl_t am_decode(input am_e m);
    am_ctl_t c;
    c = '0;
    case (m)
      AM_IDX:     begin c.use_n = 1'b1; c.pre = 1'b1; end
      AM_POSTINC: begin c.wr = 1'b1; end
      AM_POSTDEC: begin c.wr = 1'b1; c.neg = 1'b1; end
      AM_PREDEC:  begin c.wr = 1'b1; c.neg = 1'b1; c.pre = 1'b1; end
      AM_POSTADD: begin c.wr = 1'b1; c.use_n = 1'b1; end
      AM_POSTSUB: begin c.wr = 1'b1; c.use_n = 1'b1; c.neg = 1'b1; end
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/agu_step.sv
`timescale 1ns/1ps
module agu_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic          neg,
  input  logic [AW-1:0] modv,
  output logic [AW-1:0] res
);
  localparam int EW = AW + 2;

  function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] v);
    logic [AW-1:0] o;
    for (int i = 0; i < AW; i++) o[i] = v[AW-1-i];
    return o;
  endfunction

  logic          is_lin, is_rev;
  logic [AW-1:0] lin_res, rev_sum, rev_res, mod_res;
  logic [AW-1:0] mask, base;
  logic [EW-1:0] off_x, step_x, len_x, sum_x, dif_x, wrap_x;

  assign is_lin = &modv;
  assign is_rev = ~|modv;

  // linear 2^AW wraparound
  assign lin_res = neg ? ptr - step : ptr + step;

  // reverse-carry: add in mirrored bit order
  assign rev_sum = neg ? bitrev(ptr) - bitrev(step) : bitrev(ptr) + bitrev(step);
  assign rev_res = bitrev(rev_sum);

  // modulo: block mask is the modifier smeared downward
  always_comb begin
    mask[AW-1] = modv[AW-1];
    for (int i = AW-2; i >= 0; i--) mask[i] = mask[i+1] | modv[i];
  end

  assign base   = ptr & ~mask;
  assign off_x  = {2'b00, ptr & mask};
  assign step_x = {2'b00, step};
  assign len_x  = {2'b00, modv} + EW'(1);
  assign sum_x  = off_x + step_x;
  assign dif_x  = off_x - step_x;

  always_comb begin
    if (neg) wrap_x = dif_x[EW-1] ? dif_x + len_x : dif_x;
    else     wrap_x = (sum_x >= len_x) ? sum_x - len_x : sum_x;
  end

  assign mod_res = AW'({2'b00, base} | (wrap_x & {2'b00, mask}));

  always_comb begin
    if (is_lin)      res = lin_res;
    else if (is_rev) res = rev_res;
    else             res = mod_res;
  end
endmodule

// File: rtl/agu_regfile.sv
`timescale 1ns/1ps
module agu_regfile
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [1:0]               ld_sel,
  input  logic [IW-1:0]            ld_idx,
  input  logic [AW-1:0]            ld_data,
  input  logic                     wb_en,
  input  logic [IW-1:0]            wb_idx,
  input  logic [AW-1:0]            wb_data,
  output logic [NREG-1:0][AW-1:0]  ptr_q,
  output logic [NREG-1:0][AW-1:0]  off_q,
  output logic [NREG-1:0][AW-1:0]  mod_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic          hit_ld, hit_wb;
    logic          ptr_ce, off_ce, mod_ce;
    logic [AW-1:0] ptr_d;

    assign hit_ld = ld_en && (ld_idx == IW'(g));
    assign hit_wb = wb_en && (wb_idx == IW'(g));
    assign ptr_ce = (hit_ld && ld_sel == LD_PTR) || hit_wb;
    assign off_ce = hit_ld && ld_sel == LD_STEP;
    assign mod_ce = hit_ld && ld_sel == LD_MOD;

    // pointer load takes priority over access write-back
    always_comb begin
      if (hit_ld && ld_sel == LD_PTR) ptr_d = ld_data;
      else                            ptr_d = wb_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
        off_q[g] <= '0;
        mod_q[g] <= '1;
      end else begin
        if (ptr_ce) ptr_q[g] <= ptr_d;
        if (off_ce) off_q[g] <= ld_data;
        if (mod_ce) mod_q[g] <= ld_data;
      end
    end
  end
endmodule

// File: rtl/agu_top.sv
`timescale 1ns/1ps
module agu_top
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_idx,
  input  logic [2:0]    acc_mode,
  output logic [AW-1:0] ea
);
  logic [NREG-1:0][AW-1:0] ptr_q, off_q, mod_q;
  logic [AW-1:0]           cur_r, cur_n, cur_m, step, upd;
  am_ctl_t                 ctl;
  logic                    wb_en;

  assign ctl   = am_decode(am_e'(acc_mode));
  assign cur_r = ptr_q[acc_idx];
  assign cur_n = off_q[acc_idx];
  assign cur_m = mod_q[acc_idx];
  assign step  = ctl.use_n ? cur_n : AW'(1);
  assign ea    = ctl.pre ? upd : cur_r;
  assign wb_en = acc_valid && ctl.wr;

  agu_step #(.AW(AW)) u_step (
    .ptr  (cur_r),
    .step (step),
    .neg  (ctl.neg),
    .modv (cur_m),
    .res  (upd)
  );

  agu_regfile #(.AW(AW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .wb_en   (wb_en),
    .wb_idx  (acc_idx),
    .wb_data (upd),
    .ptr_q   (ptr_q),
    .off_q   (off_q),
    .mod_q   (mod_q)
  );
endmodule

// File: rtl/agu_chk.sv
`timescale 1ns/1ps
module agu_chk #(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ld_en,
  input logic [1:0]              ld_sel,
  input logic [IW-1:0]           ld_idx,
  input logic [AW-1:0]           ld_data,
  input logic                    acc_valid,
  input logic [IW-1:0]           acc_idx,
  input logic [2:0]              acc_mode,
  input logic [AW-1:0]           ea,
  input logic [NREG-1:0][AW-1:0] ptr_q,
  input logic [NREG-1:0][AW-1:0] mod_q
);
  logic ptr_ld, ptr_ld_same, mode_hold, mode_post;

  assign ptr_ld      = ld_en && ld_sel == 2'd0;
  assign ptr_ld_same = ptr_ld && ld_idx == acc_idx;
  assign mode_hold   = acc_mode == 3'd0 || acc_mode == 3'd1 || acc_mode == 3'd7;
  assign mode_post   = acc_mode == 3'd2 || acc_mode == 3'd3 ||
                       acc_mode == 3'd5 || acc_mode == 3'd6;

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> ptr_q[$past(ld_idx)] == $past(ld_data)); // R2

  AST_HOLD_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && mode_hold && !ptr_ld |=> $stable(ptr_q)); // R3

  AST_POST_EA: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (mode_post || acc_mode == 3'd0) |-> ea == ptr_q[acc_idx]); // R4

  AST_PREDEC_WB: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_mode == 3'd4 && !ptr_ld_same
    |=> ptr_q[$past(acc_idx)] == $past(ea)); // R5

  AST_LIN_INC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_mode == 3'd2 && (&mod_q[acc_idx]) && !ptr_ld_same
    |=> ptr_q[$past(acc_idx)] == AW'($past(ptr_q[acc_idx]) + AW'(1))); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid && !ptr_ld |=> $stable(ptr_q)); // R9
endmodule

bind agu_top agu_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_en     (ld_en),
  .ld_sel    (ld_sel),
  .ld_idx    (ld_idx),
  .ld_data   (ld_data),
  .acc_valid (acc_valid),
  .acc_idx   (acc_idx),
  .acc_mode  (acc_mode),
  .ea        (ea),
  .ptr_q     (ptr_q),
  .mod_q     (mod_q)
);

// File: tb/tb_agu_top.sv
`timescale 1ns/1ps
module tb_agu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  ld_sel;
  logic [2:0]  ld_idx;
  logic [15:0] ld_data;
  logic        acc_valid;
  logic [2:0]  acc_idx;
  logic [2:0]  acc_mode;
  logic [15:0] ea;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  logic [15:0] sh [8];
  int          cnum   = 0;

  always #2.5ns clk = ~clk;

  agu_top dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .acc_mode(acc_mode), .ea(ea)
  );

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) o[i] = v[15-i];
    return o;
  endfunction

  // arithmetic reference for one pointer step
  function automatic logic [15:0] ref_upd(input logic [15:0] r, input logic [15:0] n,
                                          input logic [15:0] m, input bit neg);
    int len, blk, base, off, o;
    if (m == 16'hFFFF) return neg ? r - n : r + n;
    if (m == 16'h0000) return rev16(neg ? rev16(r) - rev16(n) : rev16(r) + rev16(n));
    len = int'(m) + 1;
    blk = 1;
    while (blk < len) blk = blk * 2;
    off  = int'(r) % blk;
    base = int'(r) - off;
    o    = neg ? off - int'(n) : off + int'(n);
    if (o >= len) o = o - len;
    if (o < 0)    o = o + len;
    return 16'(base + o);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] sel, input logic [2:0] idx, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] idx, output logic [15:0] v);
    acc_valid = 1'b1; acc_mode = 3'd0; acc_idx = idx;
    #1ns;
    v = ea;
    acc_valid = 1'b0;
  endtask

  task automatic run_case(input logic [15:0] r, input logic [15:0] n,
                          input logic [15:0] m, input logic [2:0] mode);
    logic [2:0]  idx, nb;
    logic [15:0] exp_ea, exp_p, v;
    string       rq;
    idx = 3'(cnum);
    nb  = 3'(cnum + 1);
    cnum++;
    do_load(2'd0, idx, r);
    do_load(2'd1, idx, n);
    do_load(2'd2, idx, m);
    sh[idx] = r;
    case (mode)
      3'd1: begin exp_ea = ref_upd(r, n, m, 1'b0); exp_p = r; end
      3'd2: begin exp_ea = r; exp_p = ref_upd(r, 16'd1, m, 1'b0); end
      3'd3: begin exp_ea = r; exp_p = ref_upd(r, 16'd1, m, 1'b1); end
      3'd4: begin exp_ea = ref_upd(r, 16'd1, m, 1'b1); exp_p = exp_ea; end
      3'd5: begin exp_ea = r; exp_p = ref_upd(r, n, m, 1'b0); end
      3'd6: begin exp_ea = r; exp_p = ref_upd(r, n, m, 1'b1); end
      default: begin exp_ea = r; exp_p = r; end
    endcase
    if (m == 16'hFFFF)      rq = "R6";
    else if (m == 16'h0000) rq = "R8";
    else                    rq = "R7";
    // access: R3/R4/R5/R10 address in the same cycle
    acc_valid = 1'b1; acc_idx = idx; acc_mode = mode;
    #1ns;
    check({rq, " ea (R3 R4 R5 R10)"}, ea, exp_ea);
    @(negedge clk);
    acc_valid = 1'b0;
    peek(idx, v);
    check({rq, " pointer after access (R3 R4 R5)"}, v, exp_p);
    sh[idx] = exp_p;
    peek(nb, v);
    check("R9 neighbour pointer untouched", v, sh[nb]);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] len;
    rst_n = 1'b0; ld_en = 1'b0; ld_sel = 2'd3; ld_idx = '0; ld_data = '0;
    acc_valid = 1'b0; acc_idx = '0; acc_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 8; i++) begin
      peek(3'(i), v);
      check("R1 pointer reset", v, 16'h0000);
      sh[i] = 16'h0000;
    end
    acc_valid = 1'b1; acc_idx = 3'd0; acc_mode = 3'd5;     // (r)+n with step 0
    @(negedge clk);
    acc_valid = 1'b1; acc_mode = 3'd3;                      // (r)- with linear modifier
    @(negedge clk);
    acc_valid = 1'b0;
    peek(3'd0, v);
    check("R1 step 0 and modifier linear", v, 16'hFFFF);
    sh[0] = 16'hFFFF;

    // R9 no update while acc_valid is low
    do_load(2'd0, 3'd4, 16'h1111);
    sh[4] = 16'h1111;
    acc_valid = 1'b0; acc_idx = 3'd4; acc_mode = 3'd2;
    @(negedge clk);
    peek(3'd4, v);
    check("R9 idle leaves pointer", v, 16'h1111);

    // R2 load beats same-cycle write-back; ld_sel 3 writes nothing
    ld_en = 1'b1; ld_sel = 2'd0; ld_idx = 3'd4; ld_data = 16'h5555;
    acc_valid = 1'b1; acc_idx = 3'd4; acc_mode = 3'd2;
    @(negedge clk);
    ld_en = 1'b0; acc_valid = 1'b0;
    peek(3'd4, v);
    check("R2 load priority", v, 16'h5555);
    do_load(2'd3, 3'd4, 16'h0F0F);
    peek(3'd4, v);
    check("R2 ld_sel none", v, 16'h5555);
    sh[4] = 16'h5555;

    // R6 linear sweep
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 3; b++)
        for (int md = 0; md < 8; md++) begin
          logic [15:0] rr, nn;
          rr = (a == 0) ? 16'h0000 : (a == 1) ? 16'h0001 : (a == 2) ? 16'h7FFF :
               (a == 3) ? 16'hFFFF : 16'h1234;
          nn = (b == 0) ? 16'h0001 : (b == 1) ? 16'h0100 : 16'hFFFF;
          run_case(rr, nn, 16'hFFFF, 3'(md));
        end

    // R8 reverse-carry sweep
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 3; b++)
        for (int md = 0; md < 8; md++) begin
          logic [15:0] rr, nn;
          rr = (a == 0) ? 16'h0000 : (a == 1) ? 16'h8000 : (a == 2) ? 16'h4000 :
               (a == 3) ? 16'hC000 : (a == 4) ? 16'hFFFF : 16'h0001;
          nn = (b == 0) ? 16'h8000 : (b == 1) ? 16'h0100 : 16'h0001;
          run_case(rr, nn, 16'h0000, 3'(md));
        end

    // R7 modulo sweep: buffer lengths 2, 5, 8, 13
    for (int k = 0; k < 4; k++) begin
      len = (k == 0) ? 16'd2 : (k == 1) ? 16'd5 : (k == 2) ? 16'd8 : 16'd13;
      for (int bs = 0; bs < 2; bs++)
        for (int off = 0; off < int'(len); off++)
          for (int b = 0; b < 3; b++)
            for (int md = 0; md < 8; md++) begin
              logic [15:0] nn;
              nn = (b == 0) ? 16'd1 : (b == 1) ? 16'd2 : len;
              run_case(((bs == 0) ? 16'h0000 : 16'hABC0) + 16'(off), nn, len - 16'd1, 3'(md));
            end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule